// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings a display panel up and takes it down again by walking through fixed step tables. Each step in a table is one of four kinds: a register write, a wait of a whole number of milliseconds, the release of the panel reset line, or the end of the table. Register writes are handed to an external register writer over a valid/ready request, and a later done pulse marks each write as finished. The serial wire protocol that carries the writes lives outside this block, as does backlight control.

A power-on request first raises the panel supply-enable line and pulls the reset line low. The sequencer then waits, releases reset, waits again, and issues the configuration writes with timed pauses in between. A power-off request runs a shorter table and finally lowers the supply-enable line. Millisecond waits are counted by a divider that makes one tick every `CLK_PER_MS` clock cycles. The divider restarts at the beginning of each wait, so a wait of N ms lasts exactly N*CLK_PER_MS cycles.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, busy, panel_on, panel_sd_ctl and wr_valid are low and panel_rst_n is high.
- R2: When on_req is sampled while the block is idle with the panel off, panel_sd_ctl goes high and panel_rst_n goes low on the next cycle. panel_rst_n goes high 10*CLK_PER_MS+2 cycles after that sampling edge. The first write request follows 1 ms after the reset release.
- R3: The power-on writes, as (address, data) in hex, are issued in this order: (09,0000) (09,4000) (0a,2000) (09,4055). Then addresses 01..08 with data 409d 0204 0100 3000 4003 000a 0021 0c00. Then addresses 10..19 with data 0103 0301 1f0f 1f0f 0707 0307 0707 0000 0004 0000. Then (09,4a55) and (05,5003).
- R4: The power-on waits are 10 ms before the reset release, 1 ms after it, 10 ms after the first write, 40 ms after the third write, 50 ms after the fourth write and 60 ms after the last bulk write. The power-off table has one 10 ms wait after its third write. Counted from the edge that samples wr_done (or the request), the next wr_valid rises 1 cycle later, plus N*CLK_PER_MS+1 cycles for each wait of N ms in between and 1 cycle for the reset release.
- R5: wr_valid stays high, with wr_addr and wr_data unchanged, until wr_ready is sampled high. The next step starts only once wr_done has been sampled.
- R6: At the end of power-on, panel_on goes high and busy goes low on the cycle after the edge that samples the last wr_done.
- R7: When off_req is sampled while the block is idle with the panel on, the block writes (09,4055) (05,4003) (0a,0000), waits 10 ms and writes (09,4000). One cycle after the last done, panel_sd_ctl, panel_on and busy go low together.
- R8: An off_req that arrives during power-on is remembered. Power-off starts straight after the power-on table ends, and busy does not drop in between.
- R9: on_req is ignored while busy or while the panel is on. off_req is ignored while the panel is off and idle, and during power-off.
- R10: wr_valid is high, and panel_rst_n is low, only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| on_req | input | 1 | Power-on request |
| off_req | input | 1 | Power-off request |
| busy | output | 1 | A sequence is running |
| panel_on | output | 1 | Power-on has completed and the panel is up |
| panel_sd_ctl | output | 1 | Panel supply enable (shutdown control, high = powered) |
| panel_rst_n | output | 1 | Panel reset, active low |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Writer accepts the request |
| wr_addr | output | 8 | Register address |
| wr_data | output | 16 | Register data |
| wr_done | input | 1 | Writer has finished the accepted write |

## Verification
The assertions assume that the register writer raises wr_done only after it has accepted a request, and never in the same cycle as wr_ready. They also assume that CLK_PER_MS is at least 2. The bench's writer model holds to both: it drives ready only after it has seen valid, drops ready on the next cycle, and pulses done one or two cycles later. It varies the ready and done latencies from write to write. Requests are one-cycle pulses, some placed deliberately in the middle of a running sequence.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int IDX_W = 5;

  typedef enum logic [1:0] {E_WR, E_WAIT, E_RSTREL, E_END} ekind_t;

  typedef struct packed {
    ekind_t      kind;
    logic [7:0]  addr;
    logic [15:0] data;   // write data, or wait length in ms
  } entry_t;

  function automatic entry_t mk_wr(input logic [7:0] a, input logic [15:0] d);
    entry_t e;
    e.kind = E_WR; e.addr = a; e.data = d;
    return e;
  endfunction

  function automatic entry_t mk_wait(input logic [15:0] ms);
    entry_t e;
    e.kind = E_WAIT; e.addr = 8'h00; e.data = ms;
    return e;
  endfunction

  function automatic entry_t mk_kind(input ekind_t k);
    entry_t e;
    e.kind = k; e.addr = 8'h00; e.data = 16'h0000;
    return e;
  endfunction

  // cycles spent in a wait step of ms milliseconds, from its start to the next step
  function automatic int unsigned wait_cost(input int unsigned ms, input int unsigned cpm);
    return ms * cpm + 1;
  endfunction

  function automatic entry_t up_step(input logic [IDX_W-1:0] i);
    case (i)
      5'd0:  up_step = mk_wait(16'd10);
      5'd1:  up_step = mk_kind(E_RSTREL);
      5'd2:  up_step = mk_wait(16'd1);
      5'd3:  up_step = mk_wr(8'h09, 16'h0000);
      5'd4:  up_step = mk_wait(16'd10);
      5'd5:  up_step = mk_wr(8'h09, 16'h4000);
      5'd6:  up_step = mk_wr(8'h0a, 16'h2000);
      5'd7:  up_step = mk_wait(16'd40);
      5'd8:  up_step = mk_wr(8'h09, 16'h4055);
      5'd9:  up_step = mk_wait(16'd50);
      5'd10: up_step = mk_wr(8'h01, 16'h409d);
      5'd11: up_step = mk_wr(8'h02, 16'h0204);
      5'd12: up_step = mk_wr(8'h03, 16'h0100);
      5'd13: up_step = mk_wr(8'h04, 16'h3000);
      5'd14: up_step = mk_wr(8'h05, 16'h4003);
      5'd15: up_step = mk_wr(8'h06, 16'h000a);
      5'd16: up_step = mk_wr(8'h07, 16'h0021);
      5'd17: up_step = mk_wr(8'h08, 16'h0c00);
      5'd18: up_step = mk_wr(8'h10, 16'h0103);
      5'd19: up_step = mk_wr(8'h11, 16'h0301);
      5'd20: up_step = mk_wr(8'h12, 16'h1f0f);
      5'd21: up_step = mk_wr(8'h13, 16'h1f0f);
      5'd22: up_step = mk_wr(8'h14, 16'h0707);
      5'd23: up_step = mk_wr(8'h15, 16'h0307);
      5'd24: up_step = mk_wr(8'h16, 16'h0707);
      5'd25: up_step = mk_wr(8'h17, 16'h0000);
      5'd26: up_step = mk_wr(8'h18, 16'h0004);
      5'd27: up_step = mk_wr(8'h19, 16'h0000);
      5'd28: up_step = mk_wait(16'd60);
      5'd29: up_step = mk_wr(8'h09, 16'h4a55);
      5'd30: up_step = mk_wr(8'h05, 16'h5003);
      default: up_step = mk_kind(E_END);
    endcase
  endfunction

  function automatic entry_t down_step(input logic [IDX_W-1:0] i);
    case (i)
      5'd0: down_step = mk_wr(8'h09, 16'h4055);
      5'd1: down_step = mk_wr(8'h05, 16'h4003);
      5'd2: down_step = mk_wr(8'h0a, 16'h0000);
      5'd3: down_step = mk_wait(16'd10);
      5'd4: down_step = mk_wr(8'h09, 16'h4000);
      default: down_step = mk_kind(E_END);
    endcase
  endfunction
endpackage

// File: rtl/pps_ms_tick.sv
module pps_ms_tick #(
  parameter int CLK_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pps_delay_cnt.sv
module pps_delay_cnt #(
  parameter int CLK_PER_MS = 100000,
  parameter int MS_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms,
  output logic            expire
);
  logic            running;
  logic [MS_W-1:0] rem;
  logic            ms_tick;

  pps_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start | ~running),
    .tick  (ms_tick)
  );

  assign expire = running && ms_tick && (rem == MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      rem     <= '0;
    end else if (start) begin
      running <= (ms != '0);
      rem     <= ms;
    end else if (expire) begin
      running <= 1'b0;
    end else if (running && ms_tick) begin
      rem <= rem - 1'b1;
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int CLK_PER_MS = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        on_req,
  input  logic        off_req,
  output logic        busy,
  output logic        panel_on,
  output logic        panel_sd_ctl,
  output logic        panel_rst_n,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [7:0]  wr_addr,
  output logic [15:0] wr_data,
  input  logic        wr_done
);
  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_WREQ, S_WACK, S_DLY} st_t;

  st_t            st;
  logic           down_mode;
  logic [IDX_W-1:0] idx;
  logic           pend_off;
  entry_t         cur;

  always_comb cur = down_mode ? down_step(idx) : up_step(idx);

  // named internal events
  logic start_on, start_off, seq_end, dly_start, dly_expire, wr_accept;
  assign start_on   = (st == S_IDLE) && on_req && !panel_on;
  assign start_off  = (st == S_IDLE) && off_req && panel_on && !start_on;
  assign seq_end    = (st == S_EXEC) && (cur.kind == E_END);
  assign dly_start  = (st == S_EXEC) && (cur.kind == E_WAIT);
  assign wr_accept  = wr_valid && wr_ready;
  assign busy       = (st != S_IDLE);

  pps_delay_cnt #(.CLK_PER_MS(CLK_PER_MS), .MS_W(16)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (dly_start),
    .ms     (cur.data),
    .expire (dly_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      down_mode    <= 1'b0;
      idx          <= '0;
      pend_off     <= 1'b0;
      panel_on     <= 1'b0;
      panel_sd_ctl <= 1'b0;
      panel_rst_n  <= 1'b1;
      wr_valid     <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
    end else begin
      if (off_req && busy && !down_mode) pend_off <= 1'b1;
      case (st)
        S_IDLE: begin
          if (start_on) begin
            panel_sd_ctl <= 1'b1;
            panel_rst_n  <= 1'b0;
            down_mode    <= 1'b0;
            idx          <= '0;
            pend_off     <= 1'b0;
            st           <= S_EXEC;
          end else if (start_off) begin
            down_mode <= 1'b1;
            idx       <= '0;
            st        <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (seq_end) begin
            if (!down_mode) begin
              panel_on <= 1'b1;
              if (pend_off || off_req) begin
                down_mode <= 1'b1;
                idx       <= '0;
                pend_off  <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              panel_sd_ctl <= 1'b0;
              panel_on     <= 1'b0;
              st           <= S_IDLE;
            end
          end else if (dly_start) begin
            st <= S_DLY;
          end else if (cur.kind == E_RSTREL) begin
            panel_rst_n <= 1'b1;
            idx         <= idx + 1'b1;
          end else begin
            wr_valid <= 1'b1;
            wr_addr  <= cur.addr;
            wr_data  <= cur.data;
            st       <= S_WREQ;
          end
        end
        S_WREQ: if (wr_accept) begin
          wr_valid <= 1'b0;
          st       <= S_WACK;
        end
        S_WACK: if (wr_done) begin
          idx <= idx + 1'b1;
          st  <= S_EXEC;
        end
        S_DLY: if (dly_expire) begin
          idx <= idx + 1'b1;
          st  <= S_EXEC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pps_chk.sv
module pps_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        panel_on,
  input logic        panel_sd_ctl,
  input logic        panel_rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [7:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        dly_expire
);
  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R10
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  // R10
  rst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> busy && panel_sd_ctl);

  // R2
  write_after_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> panel_rst_n && panel_sd_ctl);

  // R6
  on_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panel_on |-> panel_sd_ctl && panel_rst_n);

  // R4
  dly_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_expire |-> !wr_valid && busy);

  // R7
  sd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_sd_ctl) |-> !panel_on && !busy);
endmodule

bind panel_pwr_seq pps_chk u_pps_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .panel_on     (panel_on),
  .panel_sd_ctl (panel_sd_ctl),
  .panel_rst_n  (panel_rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .dly_expire   (dly_expire)
);

// File: tb/panel_pwr_seq_bench.sv
module panel_pwr_seq_bench;
  localparam int C = 4;

  logic clk = 1'b0, rst_n = 1'b0, on_req = 1'b0, off_req = 1'b0;
  logic busy, panel_on, panel_sd_ctl, panel_rst_n, wr_valid, wr_ready, wr_done;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  always #5 clk = ~clk;

  panel_pwr_seq #(.CLK_PER_MS(C)) u_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .busy(busy), .panel_on(panel_on), .panel_sd_ctl(panel_sd_ctl),
    .panel_rst_n(panel_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected writes: 0..23 power-on, 24..27 power-off
  logic [7:0]  ea [0:27];
  logic [15:0] ed [0:27];
  int          eg [0:27];
  initial begin
    logic [15:0] bulk [0:17] = '{16'h409d, 16'h0204, 16'h0100, 16'h3000, 16'h4003,
      16'h000a, 16'h0021, 16'h0c00, 16'h0103, 16'h0301, 16'h1f0f, 16'h1f0f,
      16'h0707, 16'h0307, 16'h0707, 16'h0000, 16'h0004, 16'h0000};
    ea[0] = 8'h09; ed[0] = 16'h0000; eg[0] = 2 + (10*C+1) + 1 + (1*C+1);
    ea[1] = 8'h09; ed[1] = 16'h4000; eg[1] = 2 + (10*C+1);
    ea[2] = 8'h0a; ed[2] = 16'h2000; eg[2] = 2;
    ea[3] = 8'h09; ed[3] = 16'h4055; eg[3] = 2 + (40*C+1);
    for (int k = 0; k < 18; k++) begin
      ea[4+k] = (k < 8) ? 8'(k + 1) : 8'(16 + k - 8);
      ed[4+k] = bulk[k];
      eg[4+k] = 2;
    end
    eg[4] = 2 + (50*C+1);
    ea[22] = 8'h09; ed[22] = 16'h4a55; eg[22] = 2 + (60*C+1);
    ea[23] = 8'h05; ed[23] = 16'h5003; eg[23] = 2;
    ea[24] = 8'h09; ed[24] = 16'h4055; eg[24] = 2;
    ea[25] = 8'h05; ed[25] = 16'h4003; eg[25] = 2;
    ea[26] = 8'h0a; ed[26] = 16'h0000; eg[26] = 2;
    ea[27] = 8'h09; ed[27] = 16'h4000; eg[27] = 2 + (10*C+1);
  end

  // writer model and monitor
  int wptr = 0, wcnt = 0, ref_cyc = 0, last_done = 0, rst_rise = -1;
  int bad_valid = 0, bad_rst = 0, lat = 0, dl = 0, wst = 0;
  logic prev_rst = 1'b1;
  initial begin wr_ready = 1'b0; wr_done = 1'b0; end

  always @(negedge clk) begin
    if (wr_valid && !busy) bad_valid++;
    if (!panel_rst_n && !busy) bad_rst++;
    if (!prev_rst && panel_rst_n) rst_rise = cyc;
    prev_rst = panel_rst_n;
    case (wst)
      0: if (wr_valid) begin
        if (wptr < 28) begin
          check("R3/R7", "write addr", wr_addr, ea[wptr]);
          check("R3/R7", "write data", wr_data, ed[wptr]);
          check("R4", "cycles to write request", cyc - ref_cyc, eg[wptr]);
        end else check("R3", "extra write", wptr, 27);
        wptr++;
        lat = wcnt % 3;
        if (lat == 0) begin wr_ready = 1'b1; wst = 2; end else wst = 1;
      end
      1: begin lat--; if (lat == 0) begin wr_ready = 1'b1; wst = 2; end end
      2: begin
        wr_ready = 1'b0;
        check("R5", "valid dropped after accept", wr_valid, 0);
        dl = (wcnt % 2) + 1; wst = 3;
      end
      3: begin
        dl--;
        if (dl == 0) begin
          wr_done = 1'b1; last_done = cyc; ref_cyc = cyc; wcnt++; wst = 4;
        end
      end
      default: begin wr_done = 1'b0; wst = 0; end
    endcase
  end

  task automatic pulse_on();
    @(negedge clk); on_req = 1'b1; ref_cyc = cyc;
    @(negedge clk); on_req = 1'b0;
  endtask
  task automatic pulse_off();
    @(negedge clk); off_req = 1'b1; ref_cyc = cyc;
    @(negedge clk); off_req = 1'b0;
  endtask

  int falls = 0, saw_on = 0;
  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      if (panel_on) saw_on = 1;
      n++;
    end
    check("watchdog", "sequence finished", busy, 0);
    check(req, "busy falls one cycle after last done", cyc - last_done, 2);
  endtask

  initial begin
    int t0, w;
    repeat (3) @(negedge clk);
    // R1
    check("R1", "busy", busy, 0);
    check("R1", "panel_on", panel_on, 0);
    check("R1", "sd_ctl", panel_sd_ctl, 0);
    check("R1", "rst_n", panel_rst_n, 1);
    check("R1", "wr_valid", wr_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // power-on
    wptr = 0;
    @(negedge clk); on_req = 1'b1; ref_cyc = cyc; t0 = cyc;
    @(negedge clk); on_req = 1'b0;
    check("R2", "busy after on_req", busy, 1);
    check("R2", "sd_ctl high", panel_sd_ctl, 1);
    check("R2", "rst_n low", panel_rst_n, 0);
    wait_idle("R6");
    check("R2", "reset release cycle", rst_rise - t0, 10*C + 3);
    check("R3", "power-on write count", wptr, 24);
    check("R6", "panel_on", panel_on, 1);

    // R9: on while on is ignored
    w = wptr;
    pulse_on();
    repeat (20) @(negedge clk);
    check("R9", "on_req while on: busy", busy, 0);
    check("R9", "on_req while on: writes", wptr, w);

    // power-off; second off during it is ignored (R9)
    wptr = 24;
    pulse_off();
    repeat (3) @(negedge clk);
    off_req = 1'b1; @(negedge clk); off_req = 1'b0;
    wait_idle("R7");
    check("R7", "power-off write count", wptr, 28);
    check("R7", "sd_ctl low", panel_sd_ctl, 0);
    check("R7", "panel_on low", panel_on, 0);
    repeat (20) @(negedge clk);
    check("R9", "off during off: no restart", busy, 0);

    // R9: off while off is ignored
    pulse_off();
    repeat (20) @(negedge clk);
    check("R9", "off_req while off: busy", busy, 0);
    check("R9", "off_req while off: sd_ctl", panel_sd_ctl, 0);

    // R8: off held during on; extra on ignored (R9)
    wptr = 0; saw_on = 0; eg[24] = 3;
    pulse_on();
    while (wptr < 6) @(negedge clk);
    off_req = 1'b1; @(negedge clk); off_req = 1'b0;
    on_req = 1'b1; @(negedge clk); on_req = 1'b0;
    falls = 0;
    while (wptr < 28 && falls == 0 && cyc < 100000) begin
      @(negedge clk);
      if (!busy) falls++;
      if (panel_on) saw_on = 1;
    end
    check("R8", "busy stayed high into power-off", falls, 0);
    wait_idle("R8");
    check("R8", "all writes issued", wptr, 28);
    check("R8", "panel_on seen between sequences", saw_on, 1);
    check("R8", "sd_ctl low at end", panel_sd_ctl, 0);

    // R10
    check("R10", "wr_valid outside busy", bad_valid, 0);
    check("R10", "rst_n low outside busy", bad_rst, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule